// File: doc/BRIEF.md
# Interleaved Memory Issue Rule Checker

This block sits beside the memory issue stage of a wide-issue processor whose memory references are scheduled entirely by the compiler. In every beat (one clock cycle) up to four memory references may be presented together. Each one carries a valid bit, a load/store flag, the low word-address bits that select its RAM bank, and the number of the data-return bus it has been assigned. The block checks the group against the issue rules of an eight-bank, four-controller interleaved memory. It reports each broken rule per reference and per rule class. A reference that breaks any rule is rejected and leaves no trace in the block's state.

The bank rule spans time. A bank that accepted a reference stays busy for the three following beats, so it can take a new reference no sooner than four beats later. The block also models the memory's fixed eight-stage access pipeline. Each accepted load raises a write-back strobe on its own reference slot exactly seven beats after it was issued, which is the stage in which the register write happens.

A broken rule is a scheduling fault to be reported, not a hazard to stall on. Within a beat, a lower slot index has priority: only the later of two colliding references is flagged.

Top module: `mem_issue_checker`

## Requirements
- R1: After synchronous reset, no bank is busy and `wb_strobe` is all zero, so four references to distinct banks, controllers and buses issued in the first beat are all accepted.
- R2: The 3-bit address field of a slot is its bank number (0 to 7). Its upper two bits [2:1] are its controller number, so banks 2k and 2k+1 share controller k.
- R3: A valid slot i gets `viol_ctrl[i]` when some valid slot j < i in the same beat uses the same controller.
- R4: A valid slot i gets `viol_bus[i]` when some valid slot j < i in the same beat uses the same 2-bit return bus.
- R5: A valid slot i gets `viol_bank[i]` when some valid slot j < i in the same beat uses the same bank.
- R6: A valid slot gets `viol_bank` when its bank accepted a reference 1, 2 or 3 beats earlier. A gap of 4 or more beats is allowed.
- R7: A slot whose valid bit is low gets no flags, is not accepted, and is never compared against other slots.
- R8: A rejected reference does not make its bank busy and produces no write-back.
- R9: `ref_accept[i]` is high exactly when slot i is valid, not in reset, and has none of its three flags set.
- R10: An accepted load on slot i raises `wb_strobe[i]` exactly 7 beats after its issue beat. Accepted stores raise no strobe.
- R11: One reference may carry several flags at once. A same-beat bank repeat also shows a controller flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Beat clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_valid | input | NREF | Per-slot reference present |
| ref_load | input | NREF | Per-slot 1 = load, 0 = store |
| ref_addr | input | NREF*3 | Per-slot low word-address bits (bank field), slot i at [3i+2:3i] |
| ref_bus | input | NREF*2 | Per-slot return-bus number, slot i at [2i+1:2i] |
| viol_ctrl | output | NREF | Controller clash flag per slot |
| viol_bus | output | NREF | Return-bus clash flag per slot |
| viol_bank | output | NREF | Bank-timing flag per slot (same beat or within the busy window) |
| ref_accept | output | NREF | Slot accepted into the access pipeline |
| wb_strobe | output | NREF | Register write-back of the load issued from this slot 7 beats ago |

## Verification
The bench goes after the edges of the bank window. A bank reused at gaps of 3 and 4 beats separates a busy window that is one beat too long from one that is one beat too short. Rejected references are followed by a legal reuse of the same bank the next beat, which a design that records rejected starts would wrongly refuse. Invalid slots are loaded with colliding fields, so a design that compares them produces false flags. Same-beat collisions on slots in different orders expose a design with the wrong priority direction, and mixed load/store traffic shows a strobe that lands one beat early or late, or that fires for a store.

// File: rtl/mic_pkg.sv
package mic_pkg;
    localparam int NREF_D   = 4;
    localparam int BANK_W   = 3;
    localparam int CTRL_W   = 2;
    localparam int BUS_W    = 2;
    localparam int NBANK    = 1 << BANK_W;
    localparam int NCTRL    = 1 << CTRL_W;
    localparam int NBUS     = 1 << BUS_W;
    localparam int BANK_GAP = 4;   // minimum beats between starts on one bank
    localparam int WB_LAT   = 7;   // issue beat to register-write beat

    typedef logic [BANK_W-1:0] bank_t;
    typedef logic [CTRL_W-1:0] ctrl_t;
    typedef logic [BUS_W-1:0]  bus_t;

    typedef struct packed {
        logic ctrl;
        logic bus;
        logic bank;
    } viol_t;

    // Controller is the upper part of the bank number.
    function automatic ctrl_t ctrl_of(input bank_t b);
        return b[BANK_W-1 -: CTRL_W];
    endfunction
endpackage

// File: rtl/mic_rule_check.sv
module mic_rule_check
    import mic_pkg::*;
#(
    parameter int NREF = NREF_D
) (
    input  logic [NREF-1:0]        valid,
    input  bank_t [NREF-1:0]       bank,
    input  bus_t [NREF-1:0]        bus,
    input  logic [NBANK-1:0]       bank_busy,
    output viol_t [NREF-1:0]       viol
);
    always_comb begin
        viol = '0;
        for (int i = 0; i < NREF; i++) begin
            if (valid[i]) begin
                viol[i].bank = bank_busy[bank[i]];
                for (int j = 0; j < NREF; j++) begin
                    if (j < i && valid[j]) begin
                        if (ctrl_of(bank[j]) == ctrl_of(bank[i])) viol[i].ctrl = 1'b1;
                        if (bus[j] == bus[i])                     viol[i].bus  = 1'b1;
                        if (bank[j] == bank[i])                   viol[i].bank = 1'b1;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/mic_bank_history.sv
module mic_bank_history
    import mic_pkg::*;
#(
    parameter int NB    = NBANK,
    parameter int DEPTH = BANK_GAP - 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [NB-1:0] start,
    output logic [NB-1:0] busy
);
    logic [NB-1:0] row [DEPTH];

    for (genvar k = 0; k < DEPTH; k++) begin : g_row
        if (k == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) row[k] <= '0;
                else     row[k] <= start;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) row[k] <= '0;
                else     row[k] <= row[k-1];
            end
        end
    end

    always_comb begin
        busy = '0;
        for (int k = 0; k < DEPTH; k++) busy = busy | row[k];
    end
endmodule

// File: rtl/mic_latency_pipe.sv
module mic_latency_pipe
    import mic_pkg::*;
#(
    parameter int W   = NREF_D,
    parameter int LAT = WB_LAT
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] in_mask,
    output logic [W-1:0] out_mask
);
    logic [W-1:0] stage [LAT];

    for (genvar s = 0; s < LAT; s++) begin : g_stage
        if (s == 0) begin : g_head
            always_ff @(posedge clk) begin
                if (rst) stage[s] <= '0;
                else     stage[s] <= in_mask;
            end
        end else begin : g_body
            always_ff @(posedge clk) begin
                if (rst) stage[s] <= '0;
                else     stage[s] <= stage[s-1];
            end
        end
    end

    assign out_mask = stage[LAT-1];
endmodule

// File: rtl/mem_issue_checker.sv
module mem_issue_checker
    import mic_pkg::*;
#(
    parameter int NREF = NREF_D
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NREF-1:0]       ref_valid,
    input  logic [NREF-1:0]       ref_load,
    input  logic [NREF*BANK_W-1:0] ref_addr,
    input  logic [NREF*BUS_W-1:0] ref_bus,
    output logic [NREF-1:0]       viol_ctrl,
    output logic [NREF-1:0]       viol_bus,
    output logic [NREF-1:0]       viol_bank,
    output logic [NREF-1:0]       ref_accept,
    output logic [NREF-1:0]       wb_strobe
);
    bank_t [NREF-1:0] bank;
    bus_t  [NREF-1:0] bus;
    viol_t [NREF-1:0] viol;
    logic [NBANK-1:0] busy;
    logic [NBANK-1:0] start_mask;

    for (genvar g = 0; g < NREF; g++) begin : g_slot
        assign bank[g]       = ref_addr[g*BANK_W +: BANK_W];
        assign bus[g]        = ref_bus[g*BUS_W +: BUS_W];
        assign viol_ctrl[g]  = viol[g].ctrl;
        assign viol_bus[g]   = viol[g].bus;
        assign viol_bank[g]  = viol[g].bank;
        assign ref_accept[g] = ref_valid[g] & ~rst & ~(|viol[g]);
    end

    mic_rule_check #(.NREF(NREF)) u_rules (
        .valid     (ref_valid),
        .bank      (bank),
        .bus       (bus),
        .bank_busy (busy),
        .viol      (viol)
    );

    always_comb begin
        start_mask = '0;
        for (int i = 0; i < NREF; i++)
            if (ref_accept[i]) start_mask[bank[i]] = 1'b1;
    end

    mic_bank_history #(.NB(NBANK), .DEPTH(BANK_GAP - 1)) u_hist (
        .clk   (clk),
        .rst   (rst),
        .start (start_mask),
        .busy  (busy)
    );

    mic_latency_pipe #(.W(NREF), .LAT(WB_LAT)) u_lat (
        .clk      (clk),
        .rst      (rst),
        .in_mask  (ref_accept & ref_load),
        .out_mask (wb_strobe)
    );

    // Occupancy of accepted references, used only by the checks below.
    logic [NCTRL-1:0] acc_ctrl;
    logic [NBUS-1:0]  acc_bus;
    always_comb begin
        acc_ctrl = '0;
        acc_bus  = '0;
        for (int i = 0; i < NREF; i++) begin
            if (ref_accept[i]) begin
                acc_ctrl[ctrl_of(bank[i])] = 1'b1;
                acc_bus[bus[i]]            = 1'b1;
            end
        end
    end

    assert_ctrl_unique_R3: assert property (@(posedge clk) disable iff (rst)
        $countones(acc_ctrl) == $countones(ref_accept));

    assert_bus_unique_R4: assert property (@(posedge clk) disable iff (rst)
        $countones(acc_bus) == $countones(ref_accept));

    assert_bank_unique_R5: assert property (@(posedge clk) disable iff (rst)
        $countones(start_mask) == $countones(ref_accept));

    assert_bank_gap_R6: assert property (@(posedge clk) disable iff (rst)
        (start_mask & $past(start_mask)) == '0);

    assert_quiet_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (wb_strobe == '0));
endmodule

// File: tb/mem_issue_checker_tb.sv
`timescale 1ns/1ps
module mem_issue_checker_tb;
    localparam int N = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [N-1:0]   ref_valid = '0;
    logic [N-1:0]   ref_load  = '0;
    logic [N*3-1:0] ref_addr  = '0;
    logic [N*2-1:0] ref_bus   = '0;
    logic [N-1:0] viol_ctrl, viol_bus, viol_bank, ref_accept, wb_strobe;

    always #10 clk = ~clk;

    mem_issue_checker u_dut (
        .clk(clk), .rst(rst),
        .ref_valid(ref_valid), .ref_load(ref_load),
        .ref_addr(ref_addr), .ref_bus(ref_bus),
        .viol_ctrl(viol_ctrl), .viol_bus(viol_bus), .viol_bank(viol_bank),
        .ref_accept(ref_accept), .wb_strobe(wb_strobe)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;
    int cyc = 0;
    int last_start [8];
    logic [N-1:0] wb_exp [1024];

    // pending stimulus, applied at the next falling edge
    logic [N-1:0] pv, pl;
    int pa [N];
    int pb [N];

    task automatic chk(input string tag, input logic [N-1:0] got, input logic [N-1:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s beat %0d got %b exp %b", tag, cyc, got, exp);
        end
    endtask

    task automatic clr();
        pv = '0; pl = '0;
        for (int i = 0; i < N; i++) begin pa[i] = 0; pb[i] = 0; end
    endtask

    task automatic put(input int i, input bit ld, input int a, input int b);
        pv[i] = 1'b1; pl[i] = ld; pa[i] = a; pb[i] = b;
    endtask

    task automatic step(input string note);
        logic [N-1:0] ec, eb, ek, ea;
        @(negedge clk);
        ref_valid = pv;
        ref_load  = pl;
        for (int i = 0; i < N; i++) begin
            ref_addr[i*3 +: 3] = pa[i][2:0];
            ref_bus[i*2 +: 2]  = pb[i][1:0];
        end
        #5;
        ec = '0; eb = '0; ek = '0;
        for (int i = 0; i < N; i++) begin
            if (pv[i]) begin
                if (cyc - last_start[pa[i]] < 4) ek[i] = 1'b1;
                for (int j = 0; j < i; j++) begin
                    if (pv[j]) begin
                        if ((pa[j] / 2) == (pa[i] / 2)) ec[i] = 1'b1;
                        if (pb[j] == pb[i]) eb[i] = 1'b1;
                        if (pa[j] == pa[i]) ek[i] = 1'b1;
                    end
                end
            end
        end
        ea = pv & ~(ec | eb | ek);
        chk({note, " R3 ctrl"},   viol_ctrl,  ec);
        chk({note, " R4 bus"},    viol_bus,   eb);
        chk({note, " R5/R6 bank"}, viol_bank, ek);
        chk({note, " R9 accept"}, ref_accept, ea);
        chk({note, " R10 wb"},    wb_strobe,  wb_exp[cyc]);
        for (int i = 0; i < N; i++) begin
            if (ea[i]) begin
                last_start[pa[i]] = cyc;
                if (pl[i]) wb_exp[cyc + 7][i] = 1'b1;
            end
        end
        @(posedge clk);
        cyc++;
    endtask

    initial begin
        #(20 * 100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < 1024; k++) wb_exp[k] = '0;
        for (int b = 0; b < 8; b++) last_start[b] = -100;
        clr();
        repeat (5) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: empty history right after reset, all four accepted
        clr(); put(0,1,0,0); put(1,1,2,1); put(2,1,4,2); put(3,1,6,3);
        step("R1 reset");
        // R6: same banks one beat later
        step("R6 gap1");
        clr(); step("R6 idle");
        // R6: bank 0 at gap 3 is busy
        clr(); put(0,0,0,0); step("R6 gap3");
        // R6: bank 2 at gap 4 is free
        clr(); put(0,0,2,0); step("R6 gap4");
        clr(); repeat (4) step("R10 drain");
        // R2/R3: banks 0 and 1 share controller 0; bank field 1 vs 3 differ
        clr(); put(0,1,0,0); put(1,1,1,1); step("R2 R3 ctrl");
        clr(); repeat (4) step("idle");
        // R3 priority: only later slot flagged, collision in reverse slots
        clr(); put(2,1,5,0); put(3,1,4,1); step("R3 prio");
        clr(); repeat (4) step("idle");
        // R4: bus clash
        clr(); put(0,1,0,2); put(1,0,2,2); put(3,1,4,2); step("R4 bus");
        clr(); repeat (4) step("idle");
        // R5/R11: same bank same beat carries ctrl and bank flags
        clr(); put(0,1,3,0); put(2,1,3,1); step("R5 R11 samebank");
        clr(); repeat (4) step("idle");
        // R7: invalid slots with colliding fields are ignored
        clr(); put(1,1,6,3); pa[0] = 6; pb[0] = 3; pa[2] = 7; pb[2] = 3;
        step("R7 invalid");
        clr(); repeat (4) step("idle");
        // R8: rejected ref on bank 5 does not occupy it
        clr(); put(0,1,4,0); put(1,1,5,0); step("R8 reject");
        clr(); put(0,1,5,1); step("R8 reuse");
        // R10: stores never write back
        clr(); repeat (4) step("idle");
        clr(); put(0,0,0,0); put(1,0,2,1); step("R10 store");
        clr(); repeat (8) step("R10 drain");

        // mixed random traffic
        for (int n = 0; n < 400; n++) begin
            clr();
            for (int i = 0; i < N; i++) begin
                pv[i] = ($urandom % 3) != 0;
                pl[i] = $urandom % 2;
                pa[i] = $urandom % 8;
                pb[i] = $urandom % 4;
            end
            step("rand");
        end
        clr(); repeat (8) step("R10 tail");

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule